// File: doc/BRIEF.md
# Bit Manipulation and Decimal Nibble Rotate Unit

This execution unit serves an 8-bit accumulator processor. It covers two instruction groups. The first group tests, clears or sets a single bit of an operand byte. The second group moves 4-bit nibbles between the accumulator and a memory byte, in either direction. The operand byte has already been read from a register or from memory when it reaches the unit. Instruction fetch, bus timing and index address calculation happen elsewhere. The core is combinational. Its results are captured in output registers, so each accepted request produces its result exactly one clock later.

The sequencer drives `inValid` together with the fields of the request. `prefixExt` tells the unit which opcode page the byte belongs to: low selects the bit-operation page and high selects the extended page. The outputs are the byte to write back (`result` with `writeEn`), the next accumulator value and the next flag byte. Flag bits 5 and 3 of a bit test come from different places depending on the addressing form. For the memory form they come from a hidden 16-bit address temporary. For the register form they come from the tested value.

Top module: `bit_nibble_unit`

## Requirements
- R1: While `rstN` is low and after reset, `outValid`, `writeEn`, `result`, `accOut` and `flagsOut` are all zero.
- R2: A request with `inValid` high appears on the outputs after the next rising clock edge, with `outValid` high. In a cycle where `inValid` is low, `outValid` goes low and the data outputs keep their previous values.
- R3: With `prefixExt` low, `opcode[7:6]` selects the operation: 01 is test, 10 is clear and 11 is set. `opcode[5:3]` is the bit index. `opcode[2:0]` selects the operand, and 110 marks the memory form.
- R4: The flag byte is laid out as S=7, Z=6, X5=5, H=4, X3=3, P=2, N=1, C=0. A test forms t = operand AND (1<<index). It then sets S=t[7], Z=(t==0), P=1 when t has an even number of ones, H=1 and N=0. C is kept. For a test, `result` equals the operand, `accOut` equals `accIn` and `writeEn` is 0.
- R5: A register-form test sets X5=t[5] and X3=t[3].
- R6: A memory-form test sets X5=`addrTemp[13]` and X3=`addrTemp[11]`, whatever the value of t.
- R7: Clear outputs the operand with the indexed bit forced to 0. Set outputs the operand with the indexed bit forced to 1. Both assert `writeEn`, return `flagsIn` unchanged and leave the accumulator as it was.
- R8: With `prefixExt` high and opcode 0x67 (rotate right), `result`={A[3:0],M[7:4]} and `accOut`={A[7:4],M[3:0]}, with `writeEn` 1.
- R9: With `prefixExt` high and opcode 0x6F (rotate left), `result`={M[3:0],A[3:0]} and `accOut`={A[7:4],M[7:4]}, with `writeEn` 1.
- R10: After either rotate, S, Z, X5, X3 and P (even parity) are taken from the new accumulator. H and N are 0, and C is kept.
- R11: Any other code is passed through unchanged. This covers `prefixExt` low with `opcode[7:6]`=00, and any extended opcode other than 0x67 or 0x6F. Pass-through means `result`=operand, `accOut`=`accIn`, `flagsOut`=`flagsIn` and `writeEn` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| prefixExt | input | 1 | 0 selects the bit-operation page, 1 the extended page |
| opcode | input | 8 | Opcode byte following the prefix |
| operand | input | 8 | Operand byte, register or memory |
| accIn | input | 8 | Current accumulator |
| flagsIn | input | 8 | Current flag byte |
| addrTemp | input | 16 | Hidden address temporary |
| outValid | output | 1 | Result registers hold a fresh result |
| result | output | 8 | Byte to write back |
| accOut | output | 8 | Next accumulator |
| flagsOut | output | 8 | Next flag byte |
| writeEn | output | 1 | Write-back request for `result` |

## Verification
A wrong decode shows on the outputs one clock after the request. It appears either as a write strobe on a test or on a pass-through code, or as a flag byte with a changed carry. A wrong lane mask shows up for particular index and operand pairs. For that reason the sweep covers all 256 operand values at all eight positions, in both addressing forms. A nibble crossed in the rotate network shows up in `result` or `accOut` for nearly every operand and accumulator pair, again after one cycle.

// File: rtl/bnu_pkg.sv
package bnu_pkg;
  localparam int FLAG_S = 7;
  localparam int FLAG_Z = 6;
  localparam int FLAG_5 = 5;
  localparam int FLAG_H = 4;
  localparam int FLAG_3 = 3;
  localparam int FLAG_P = 2;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 0;

  localparam logic [2:0] MEM_SEL = 3'b110;
  localparam logic [7:0] OPC_ROT_R = 8'h67;
  localparam logic [7:0] OPC_ROT_L = 8'h6F;

  typedef struct packed {
    logic       doTest;
    logic       doClear;
    logic       doSet;
    logic       doRotR;
    logic       doRotL;
    logic       memForm;
    logic [2:0] bitIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/bnu_ctrl.sv
module bnu_ctrl
  import bnu_pkg::*;
(
  input  logic         prefixExt,
  input  logic [7:0]   opcode,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.bitIdx  = opcode[5:3];
    strobes.memForm = (opcode[2:0] == MEM_SEL);
    if (!prefixExt) begin
      unique case (opcode[7:6])
        2'b01:   strobes.doTest  = 1'b1;
        2'b10:   strobes.doClear = 1'b1;
        2'b11:   strobes.doSet   = 1'b1;
        default: ;
      endcase
    end else begin
      strobes.doRotR = (opcode == OPC_ROT_R);
      strobes.doRotL = (opcode == OPC_ROT_L);
    end
  end

  // R3: at most one operation strobe per decoded opcode
  always_comb begin
    assert_single_op_R3: assert ($onehot0({strobes.doTest, strobes.doClear, strobes.doSet,
                                           strobes.doRotR, strobes.doRotL}));
  end
endmodule

// File: rtl/bnu_datapath.sv
module bnu_datapath
  import bnu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int TAP_HI = 13,
  parameter int TAP_LO = 11
) (
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  operand,
  input  logic [DATA_W-1:0]  accIn,
  input  logic [7:0]         flagsIn,
  input  logic [ADDR_W-1:0]  addrTemp,
  output logic [DATA_W-1:0]  resultNext,
  output logic [DATA_W-1:0]  accNext,
  output logic [7:0]         flagsNext,
  output logic               writeNext
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] testedVal;
  logic [DATA_W-1:0] clearedVal;
  logic [DATA_W-1:0] setVal;
  logic [DATA_W-1:0] rotMem;
  logic [DATA_W-1:0] rotAcc;
  logic [7:0]        testFlags;
  logic [7:0]        rotFlags;
  logic              x5Src;
  logic              x3Src;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign laneMask[i]   = (int'(strobes.bitIdx) == i);
    assign testedVal[i]  = operand[i] & laneMask[i];
    assign clearedVal[i] = operand[i] & ~laneMask[i];
    assign setVal[i]     = operand[i] | laneMask[i];
  end

  assign x5Src = strobes.memForm ? addrTemp[TAP_HI] : testedVal[FLAG_5];
  assign x3Src = strobes.memForm ? addrTemp[TAP_LO] : testedVal[FLAG_3];

  always_comb begin
    testFlags         = flagsIn;
    testFlags[FLAG_S] = testedVal[DATA_W-1];
    testFlags[FLAG_Z] = (testedVal == '0);
    testFlags[FLAG_5] = x5Src;
    testFlags[FLAG_H] = 1'b1;
    testFlags[FLAG_3] = x3Src;
    testFlags[FLAG_P] = ~^testedVal;
    testFlags[FLAG_N] = 1'b0;
  end

  always_comb begin
    if (strobes.doRotR) begin
      rotMem = {accIn[NIB-1:0], operand[DATA_W-1:NIB]};
      rotAcc = {accIn[DATA_W-1:NIB], operand[NIB-1:0]};
    end else begin
      rotMem = {operand[NIB-1:0], accIn[NIB-1:0]};
      rotAcc = {accIn[DATA_W-1:NIB], operand[DATA_W-1:NIB]};
    end
  end

  always_comb begin
    rotFlags         = flagsIn;
    rotFlags[FLAG_S] = rotAcc[DATA_W-1];
    rotFlags[FLAG_Z] = (rotAcc == '0);
    rotFlags[FLAG_5] = rotAcc[5];
    rotFlags[FLAG_H] = 1'b0;
    rotFlags[FLAG_3] = rotAcc[3];
    rotFlags[FLAG_P] = ~^rotAcc;
    rotFlags[FLAG_N] = 1'b0;
  end

  always_comb begin
    resultNext = operand;
    accNext    = accIn;
    flagsNext  = flagsIn;
    writeNext  = 1'b0;
    if (strobes.doTest) begin
      flagsNext = testFlags;
    end else if (strobes.doClear) begin
      resultNext = clearedVal;
      writeNext  = 1'b1;
    end else if (strobes.doSet) begin
      resultNext = setVal;
      writeNext  = 1'b1;
    end else if (strobes.doRotR || strobes.doRotL) begin
      resultNext = rotMem;
      accNext    = rotAcc;
      flagsNext  = rotFlags;
      writeNext  = 1'b1;
    end
  end
endmodule

// File: rtl/bit_nibble_unit.sv
module bit_nibble_unit
  import bnu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int TAP_HI = 13,
  parameter int TAP_LO = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              prefixExt,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic [7:0]        flagsIn,
  input  logic [ADDR_W-1:0] addrTemp,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut,
  output logic              writeEn
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] resultNext;
  logic [DATA_W-1:0] accNext;
  logic [7:0]        flagsNext;
  logic              writeNext;

  bnu_ctrl u_ctrl (
    .prefixExt (prefixExt),
    .opcode    (opcode),
    .strobes   (strobes)
  );

  bnu_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
  ) u_datapath (
    .strobes    (strobes),
    .operand    (operand),
    .accIn      (accIn),
    .flagsIn    (flagsIn),
    .addrTemp   (addrTemp),
    .resultNext (resultNext),
    .accNext    (accNext),
    .flagsNext  (flagsNext),
    .writeNext  (writeNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      accOut   <= '0;
      flagsOut <= '0;
      writeEn  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result   <= resultNext;
        accOut   <= accNext;
        flagsOut <= flagsNext;
        writeEn  <= writeNext;
      end
    end
  end

  // R2: idle cycle drops valid and holds data
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(accOut) && $stable(flagsOut)));

  // R4: a test never writes back and keeps carry, H set, N clear
  assert_test_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !prefixExt && opcode[7:6] == 2'b01) |=>
      (!writeEn && flagsOut[FLAG_H] && !flagsOut[FLAG_N] &&
       flagsOut[FLAG_C] == $past(flagsIn[FLAG_C]) && result == $past(operand)));

  // R7: clear/set write back and leave flags alone
  assert_modify_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !prefixExt && opcode[7]) |=>
      (writeEn && flagsOut == $past(flagsIn) && accOut == $past(accIn)));

  // R10: rotates keep the high accumulator nibble and carry, clear H and N
  assert_rotate_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && prefixExt && (opcode == OPC_ROT_R || opcode == OPC_ROT_L)) |=>
      (writeEn && !flagsOut[FLAG_H] && !flagsOut[FLAG_N] &&
       flagsOut[FLAG_C] == $past(flagsIn[FLAG_C]) &&
       accOut[DATA_W-1:DATA_W/2] == $past(accIn[DATA_W-1:DATA_W/2])));

  // R11: unhandled extended opcodes pass everything through
  assert_passthrough_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && prefixExt && opcode != OPC_ROT_R && opcode != OPC_ROT_L) |=>
      (!writeEn && flagsOut == $past(flagsIn) && accOut == $past(accIn)));
endmodule

// File: tb/bit_nibble_unit_tb.sv
module bit_nibble_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        prefixExt = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  operand = '0;
  logic [7:0]  accIn = '0;
  logic [7:0]  flagsIn = '0;
  logic [15:0] addrTemp = '0;
  logic        outValid;
  logic [7:0]  result;
  logic [7:0]  accOut;
  logic [7:0]  flagsOut;
  logic        writeEn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bit_nibble_unit u_dut (
    .clk (clk), .rstN (rstN), .inValid (inValid), .prefixExt (prefixExt),
    .opcode (opcode), .operand (operand), .accIn (accIn), .flagsIn (flagsIn),
    .addrTemp (addrTemp), .outValid (outValid), .result (result),
    .accOut (accOut), .flagsOut (flagsOut), .writeEn (writeEn)
  );

  task automatic compare(input string req, input logic [7:0] eRes, input logic [7:0] eAcc,
                         input logic [7:0] eFlg, input logic eWr, input logic eVld);
    checks++;
    if (result !== eRes || accOut !== eAcc || flagsOut !== eFlg ||
        writeEn !== eWr || outValid !== eVld) begin
      fails++;
      $display("FAIL %s: got res=%02h acc=%02h flg=%02h wr=%0b vld=%0b exp res=%02h acc=%02h flg=%02h wr=%0b vld=%0b",
               req, result, accOut, flagsOut, writeEn, outValid, eRes, eAcc, eFlg, eWr, eVld);
    end
  endtask

  // Drive a request at a falling edge, check at the following falling edge.
  task automatic apply(input logic pfx, input logic [7:0] op, input logic [7:0] m,
                       input logic [7:0] a, input logic [7:0] f, input logic [15:0] t);
    prefixExt = pfx; opcode = op; operand = m; accIn = a; flagsIn = f; addrTemp = t;
    inValid = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] testFlags(input logic [7:0] m, input int b, input logic mem,
                                           input logic [7:0] f, input logic [15:0] t);
    logic [7:0] tv;
    tv = m & (8'd1 << b);
    return {tv[7], tv == 8'd0, mem ? t[13] : tv[5], 1'b1, mem ? t[11] : tv[3],
            ~^tv, 1'b0, f[0]};
  endfunction

  function automatic logic [7:0] rotFlags(input logic [7:0] na, input logic [7:0] f);
    return {na[7], na == 8'd0, na[5], 1'b0, na[3], ~^na, 1'b0, f[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 60000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lastRes, lastAcc, lastFlg;
    logic       lastWr;
    repeat (3) @(negedge clk);
    compare("R1", 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1", 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);

    // R3 R4 R5 R6 R7: every operand value and bit position, both operand forms
    for (int m = 0; m < 256; m++) begin
      for (int b = 0; b < 8; b++) begin
        for (int mem = 0; mem < 2; mem++) begin
          logic [2:0]  reg3;
          logic [7:0]  f;
          logic [15:0] t;
          logic [7:0]  mm;
          mm   = 8'(m);
          reg3 = mem ? 3'b110 : ((b[2:0] == 3'b110) ? 3'b111 : b[2:0]);
          f    = mm ^ 8'(b * 37) ^ 8'h5A;
          t    = {mm ^ 8'hC3, 8'(b * 17)} ^ 16'(m << 3);
          apply(1'b0, {2'b01, b[2:0], reg3}, mm, ~mm, f, t);
          compare(mem ? "R6" : "R5", mm, ~mm, testFlags(mm, b, mem[0], f, t), 1'b0, 1'b1);
          apply(1'b0, {2'b10, b[2:0], reg3}, mm, 8'h3C, f, t);
          compare("R7 clear", mm & ~(8'd1 << b), 8'h3C, f, 1'b1, 1'b1);
          apply(1'b0, {2'b11, b[2:0], reg3}, mm, 8'hA5, f, t);
          compare("R7 set", mm | (8'd1 << b), 8'hA5, f, 1'b1, 1'b1);
        end
      end
    end

    // R8 R9 R10: rotates over all memory bytes and a spread of accumulators
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] a, mm, f, na;
        mm = 8'(m);
        a  = 8'(k * 16 + (15 - k)) ^ 8'(m >> 4);
        f  = 8'(m + k);
        na = {a[7:4], mm[3:0]};
        apply(1'b1, 8'h67, mm, a, f, 16'h0000);
        compare("R8 R10", {a[3:0], mm[7:4]}, na, rotFlags(na, f), 1'b1, 1'b1);
        na = {a[7:4], mm[7:4]};
        apply(1'b1, 8'h6F, mm, a, f, 16'hFFFF);
        compare("R9 R10", {mm[3:0], a[3:0]}, na, rotFlags(na, f), 1'b1, 1'b1);
      end
    end
    // zero accumulator corner: Z and P set, S clear
    apply(1'b1, 8'h67, 8'h00, 8'h00, 8'h01, 16'h0);
    compare("R10 zero", 8'h00, 8'h00, 8'b0100_0101, 1'b1, 1'b1);

    // R11: unhandled codes on both pages
    for (int op = 0; op < 64; op++) begin
      apply(1'b0, 8'(op), 8'(op * 3), 8'h77, 8'(op ^ 8'h9C), 16'hABCD);
      compare("R11 page0", 8'(op * 3), 8'h77, 8'(op ^ 8'h9C), 1'b0, 1'b1);
    end
    for (int op = 0; op < 256; op++) begin
      if (op != 8'h67 && op != 8'h6F) begin
        apply(1'b1, 8'(op), 8'(~op), 8'h12, 8'(op), 16'h2800);
        compare("R11 ext", 8'(~op), 8'h12, 8'(op), 1'b0, 1'b1);
      end
    end

    // R2: idle cycles hold the data outputs and drop valid
    apply(1'b0, 8'hDE, 8'h40, 8'h99, 8'h11, 16'h0);
    lastRes = 8'h48; lastAcc = 8'h99; lastFlg = 8'h11; lastWr = 1'b1;
    compare("R2 load", lastRes, lastAcc, lastFlg, lastWr, 1'b1);
    prefixExt = 1'b1; opcode = 8'h6F; operand = 8'hFF; accIn = 8'h00;
    flagsIn = 8'hFF; inValid = 1'b0;
    @(negedge clk);
    compare("R2 hold", lastRes, lastAcc, lastFlg, lastWr, 1'b0);
    @(negedge clk);
    compare("R2 hold2", lastRes, lastAcc, lastFlg, lastWr, 1'b0);

    // R1: reset in the middle of operation
    rstN = 1'b0;
    @(negedge clk);
    compare("R1 midrun", 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule